// File: doc/BRIEF.md
# Trigger and Capture Logic Analyzer

This block is a small embedded logic analyzer that sits inside a larger design and runs on that design's own clock. It has no sample clock of its own. Two probe buses enter it. The trigger bus feeds a comparator, and the data bus feeds a sample memory built as on-chip block RAM. Because the two buses are separate, a capture can fire on address or control lines while only data-bus words are kept. The two buses may also be tied to the same signals.

The comparator works in one of two modes. In masked-pattern mode it looks for a bit pattern under a mask. In range mode it looks for an unsigned value between two bounds. Once armed, the analyzer writes one sample per clock into a circular buffer. A programmable pre-trigger count fixes how many samples land ahead of the trigger sample. After the trigger it fills the rest of the buffer and then stops. Every stored word carries a mark bit that records whether the comparator matched in that cycle.

Software drives the block through a plain synchronous register port. Through it, software arms a capture, sets the mode and the reference values, polls the status, and reads the buffer back.

Top module: `la_capture`

## Requirements
- R1: After reset, every readable register reads 0, the status word reads 0, and `cfg_rdata` is 0.
- R2: In masked-pattern mode (mode bit = 0), the comparator matches when `(trig_probe & B) == (A & B)`. Here A is register index 2 and B is register index 3.
- R3: In range mode (mode bit = 1), the comparator matches when `A <= trig_probe <= B`, compared unsigned with both bounds inclusive.
- R4: While a capture is running, each cycle stores one buffer word. Bit DATA_W of the word holds that cycle's comparator result (the mark), and bits DATA_W-1:0 hold `data_probe`.
- R5: Writing 1 to bit 0 of register index 0 (arm) does four things. It enters the armed state, resets the write address to 0 and clears the done flag. The sample in the cycle of that write is not stored, so the first stored sample goes to address 0 on the following cycle.
- R6: While armed, a comparator match is taken as the trigger only after at least PRE samples have been stored since arming. PRE is register index 4. A match in the same cycle as the PRE-th stored sample is accepted. Earlier matches are only marked.
- R7: After the trigger sample, exactly DEPTH-1-PRE further samples are stored, and then the block stops in the done state. With PRE = DEPTH-1 it stops at the trigger sample itself. No write happens in the idle or done states.
- R8: The status word is register index 5. Bit 0 is done. Bit 1 is busy (armed or post-trigger). Bits 8 and up hold the buffer address of the trigger sample.
- R9: A read with `cfg_re` returns data on `cfg_rdata` one cycle later. When `cfg_addr[AW]` is 1 the read returns the buffer word at `cfg_addr[AW-1:0]`; when it is 0 the read returns a register. A cycle without a read returns 0.
- R10: An arm write issued while a capture is armed or post-trigger restarts the capture. An arm write has priority over a match in the same cycle.
- R11: A configuration write affects the comparator from the next cycle on. The match in the write cycle uses the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | design clock that all sampling uses |
| rst_n | input | 1 | active-low synchronous reset |
| trig_probe | input | TRIG_W | bus watched by the comparator |
| data_probe | input | DATA_W | bus stored in the buffer |
| cfg_we | input | 1 | register write strobe |
| cfg_re | input | 1 | read strobe (register or buffer) |
| cfg_addr | input | AW+1 | top bit selects buffer, low bits index |
| cfg_wdata | input | REG_W | write data |
| cfg_rdata | output | REG_W | read data, one cycle after `cfg_re` |

## Verification
Two pairs of events can fall in the same cycle.

- A comparator match can coincide with the sample that completes the pre-trigger count. The bench provokes this by holding a matching trigger value from before arming with PRE = 8. The trigger address must then be exactly 8.
- An arm or reference write can coincide with a matching probe value. The bench provokes this by issuing the write while the probe matches. It then judges through the reference model and the reported trigger address that the arm wins and that the old references still decided that cycle.

A behavioural model predicts `cfg_rdata` on every clock, and full buffer dumps check the marks and the data.

// File: rtl/la_pkg.sv
package la_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_POST  = 2'd2,
        CAP_DONE  = 2'd3
    } cap_state_e;

    typedef enum logic {
        MATCH_MASKED = 1'b0,
        MATCH_RANGE  = 1'b1
    } match_mode_e;

    localparam int REG_CTRL   = 0;
    localparam int REG_MODE   = 1;
    localparam int REG_REF_A  = 2;
    localparam int REG_REF_B  = 3;
    localparam int REG_PRE    = 4;
    localparam int REG_STATUS = 5;

    localparam int STATUS_DONE_BIT = 0;
    localparam int STATUS_BUSY_BIT = 1;
    localparam int STATUS_TRIG_LSB = 8;

endpackage

// File: rtl/la_trig_cmp.sv
module la_trig_cmp
    import la_pkg::*;
#(
    parameter int W = 16
) (
    input  match_mode_e  mode,
    input  logic [W-1:0] ref_a,
    input  logic [W-1:0] ref_b,
    input  logic [W-1:0] probe,
    output logic         hit
);
    logic masked_hit;
    logic range_hit;

    always_comb begin
        masked_hit = ((probe & ref_b) == (ref_a & ref_b));
        range_hit  = (probe >= ref_a) && (probe <= ref_b);
        hit        = (mode == MATCH_RANGE) ? range_hit : masked_hit;
    end
endmodule

// File: rtl/la_sample_ram.sv
module la_sample_ram #(
    parameter int DEPTH = 1024,
    parameter int W     = 17,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl
    import la_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          hit,
    input  logic [AW-1:0] pre,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output cap_state_e    state,
    output logic [AW-1:0] trig_addr
);
    localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    typedef struct packed {
        cap_state_e    st;
        logic [AW-1:0] wp;
        logic [AW:0]   filled;
        logic [AW-1:0] post;
        logic [AW-1:0] trig;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        wr_en = 1'b0;
        if (arm) begin
            ctl_d.st     = CAP_ARMED;
            ctl_d.wp     = '0;
            ctl_d.filled = '0;
        end else begin
            case (ctl_q.st)
                CAP_ARMED: begin
                    wr_en    = 1'b1;
                    ctl_d.wp = ctl_q.wp + 1'b1;
                    if (ctl_q.filled != FULL_CNT) begin
                        ctl_d.filled = ctl_q.filled + 1'b1;
                    end
                    if (hit && (ctl_q.filled >= {1'b0, pre})) begin
                        ctl_d.trig = ctl_q.wp;
                        ctl_d.post = LAST_IDX - pre;
                        ctl_d.st   = (pre == LAST_IDX) ? CAP_DONE : CAP_POST;
                    end
                end
                CAP_POST: begin
                    wr_en      = 1'b1;
                    ctl_d.wp   = ctl_q.wp + 1'b1;
                    ctl_d.post = ctl_q.post - 1'b1;
                    if (ctl_q.post == AW'(1)) begin
                        ctl_d.st = CAP_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: CAP_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign wr_addr   = ctl_q.wp;
    assign state     = ctl_q.st;
    assign trig_addr = ctl_q.trig;
endmodule

// File: rtl/la_capture.sv
module la_capture
    import la_pkg::*;
#(
    parameter int TRIG_W = 16,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1024,
    parameter int REG_W  = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int SW    = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TRIG_W-1:0] trig_probe,
    input  logic [DATA_W-1:0] data_probe,
    input  logic              cfg_we,
    input  logic              cfg_re,
    input  logic [AW:0]       cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata
);
    typedef struct packed {
        match_mode_e       mode;
        logic [TRIG_W-1:0] ref_a;
        logic [TRIG_W-1:0] ref_b;
        logic [AW-1:0]     pre;
        logic              rd_buf;
        logic [REG_W-1:0]  rd_reg;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic          arm;
    logic          hit;
    logic          ram_we;
    logic [AW-1:0] ram_waddr;
    logic [SW-1:0] ram_q;
    logic [AW-1:0] trig_addr;
    logic [AW-1:0] idx;
    logic          reg_sel;
    logic [REG_W-1:0] status_word;
    cap_state_e    cap_state;

    la_trig_cmp #(.W(TRIG_W)) u_cmp (
        .mode  (cfg_q.mode),
        .ref_a (cfg_q.ref_a),
        .ref_b (cfg_q.ref_b),
        .probe (trig_probe),
        .hit   (hit)
    );

    la_capture_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .hit       (hit),
        .pre       (cfg_q.pre),
        .wr_en     (ram_we),
        .wr_addr   (ram_waddr),
        .state     (cap_state),
        .trig_addr (trig_addr)
    );

    la_sample_ram #(.DEPTH(DEPTH), .W(SW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata ({hit, data_probe}),
        .raddr (cfg_addr[AW-1:0]),
        .rdata (ram_q)
    );

    always_comb begin
        reg_sel = !cfg_addr[AW];
        idx     = cfg_addr[AW-1:0];
        arm     = cfg_we && reg_sel && (idx == AW'(REG_CTRL)) && cfg_wdata[0];

        status_word = '0;
        status_word[STATUS_DONE_BIT] = (cap_state == CAP_DONE);
        status_word[STATUS_BUSY_BIT] = (cap_state == CAP_ARMED) || (cap_state == CAP_POST);
        status_word[STATUS_TRIG_LSB +: AW] = trig_addr;

        cfg_d = cfg_q;
        if (cfg_we && reg_sel) begin
            case (idx)
                AW'(REG_MODE):  cfg_d.mode  = match_mode_e'(cfg_wdata[0]);
                AW'(REG_REF_A): cfg_d.ref_a = cfg_wdata[TRIG_W-1:0];
                AW'(REG_REF_B): cfg_d.ref_b = cfg_wdata[TRIG_W-1:0];
                AW'(REG_PRE):   cfg_d.pre   = cfg_wdata[AW-1:0];
                default: ;
            endcase
        end

        cfg_d.rd_buf = cfg_re && cfg_addr[AW];
        cfg_d.rd_reg = '0;
        if (cfg_re && reg_sel) begin
            case (idx)
                AW'(REG_MODE):   cfg_d.rd_reg = REG_W'(cfg_q.mode);
                AW'(REG_REF_A):  cfg_d.rd_reg = REG_W'(cfg_q.ref_a);
                AW'(REG_REF_B):  cfg_d.rd_reg = REG_W'(cfg_q.ref_b);
                AW'(REG_PRE):    cfg_d.rd_reg = REG_W'(cfg_q.pre);
                AW'(REG_STATUS): cfg_d.rd_reg = status_word;
                default:         cfg_d.rd_reg = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{mode: MATCH_MASKED, default: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_rdata = cfg_q.rd_buf ? REG_W'(ram_q) : cfg_q.rd_reg;
endmodule

// File: rtl/la_capture_chk.sv
module la_capture_chk
    import la_pkg::*;
#(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arm,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input cap_state_e    state
);
    // R5: an arm write always lands in the armed state at address 0
    a_r5_arm_restart: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (state == CAP_ARMED) && (wr_addr == '0));

    // R5: each stored sample advances the write address by one
    a_r5_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !arm) |=> (wr_addr == $past(wr_addr) + 1'b1));

    // R7: a finished capture stays finished until re-armed
    a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_DONE && !arm) |=> (state == CAP_DONE));

    // R7: nothing is written outside a running capture
    a_r7_no_write_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_IDLE || state == CAP_DONE) |-> !wr_en);

    // R10: the arm cycle stores no sample
    a_r10_arm_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> !wr_en);
endmodule

bind la_capture la_capture_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm),
    .wr_en   (ram_we),
    .wr_addr (ram_waddr),
    .state   (cap_state)
);

// File: tb/la_capture_test.sv
module la_capture_test;
    localparam int TW = 8;
    localparam int DW = 8;
    localparam int DEPTH = 32;
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] A_CTRL = 0, A_MODE = 1, A_REFA = 2, A_REFB = 3, A_PRE = 4, A_STAT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [TW-1:0] trig_probe = '0;
    logic [DW-1:0] data_probe = '0;
    logic cfg_we = 1'b0, cfg_re = 1'b0;
    logic [AW:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;

    always #4 clk = ~clk;

    la_capture #(.TRIG_W(TW), .DATA_W(DW), .DEPTH(DEPTH), .REG_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .trig_probe(trig_probe), .data_probe(data_probe),
        .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    int tests = 0, fails = 0;
    bit finished = 0;

    // behavioural reference state
    int m_state = 0;          // 0 idle, 1 armed, 2 post, 3 done
    int m_wp = 0, m_filled = 0, m_post = 0, m_trig = 0;
    int m_mode = 0, m_pre = 0;
    logic [TW-1:0] m_a = '0, m_b = '0;
    logic [DW:0] m_mem [DEPTH];

    logic [TW-1:0] tp = '0;
    logic [DW-1:0] dp = 8'h3c;
    bit exp_valid = 0;
    logic [31:0] exp_val = '0;
    string exp_tag = "R1";

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit m_hit(input logic [TW-1:0] v);
        if (m_mode == 1) return (v >= m_a) && (v <= m_b);
        return (v & m_b) == (m_a & m_b);
    endfunction

    function automatic logic [31:0] m_read(input logic [AW:0] a);
        if (a[AW]) return 32'(m_mem[a[AW-1:0]]);
        case (a)
            A_MODE: return 32'(m_mode);
            A_REFA: return 32'(m_a);
            A_REFB: return 32'(m_b);
            A_PRE:  return 32'(m_pre);
            A_STAT: return (32'(m_trig) << 8) | ((m_state == 1 || m_state == 2) ? 32'd2 : 32'd0)
                           | ((m_state == 3) ? 32'd1 : 32'd0);
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_edge(input bit we, input logic [AW:0] a, input logic [31:0] wd);
        bit h;
        bit arm;
        h = m_hit(tp);
        arm = we && (a == A_CTRL) && wd[0];
        if (arm) begin
            m_state = 1; m_wp = 0; m_filled = 0;
        end else if (m_state == 1) begin
            m_mem[m_wp] = {h, dp};
            if (h && m_filled >= m_pre) begin
                m_trig = m_wp;
                m_post = DEPTH - 1 - m_pre;
                m_state = (m_post == 0) ? 3 : 2;
            end
            m_wp = (m_wp + 1) % DEPTH;
            if (m_filled < DEPTH) m_filled++;
        end else if (m_state == 2) begin
            m_mem[m_wp] = {h, dp};
            m_wp = (m_wp + 1) % DEPTH;
            m_post--;
            if (m_post == 0) m_state = 3;
        end
        if (we && !a[AW]) begin
            case (a)
                A_MODE: m_mode = int'(wd[0]);
                A_REFA: m_a = wd[TW-1:0];
                A_REFB: m_b = wd[TW-1:0];
                A_PRE:  m_pre = int'(wd[AW-1:0]);
                default: ;
            endcase
        end
    endtask

    // one clock: compare the previous cycle's read, drive, advance the model
    task automatic step(input bit we, input bit re, input logic [AW:0] a,
                        input logic [31:0] wd, input string tag);
        @(negedge clk);
        if (exp_valid) check(exp_tag, cfg_rdata, exp_val);
        cfg_we = we; cfg_re = re; cfg_addr = a; cfg_wdata = wd;
        trig_probe = tp; data_probe = dp;
        exp_valid = 1;
        exp_tag = tag;
        exp_val = re ? m_read(a) : 32'd0;
        model_edge(we, a, wd);
        dp = dp + 8'd7;
    endtask

    task automatic wr(input logic [AW:0] a, input logic [31:0] v, input string tag);
        step(1, 0, a, v, tag);
    endtask

    task automatic poll(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 1, A_STAT, 0, tag);
    endtask

    task automatic run_to_done(input string tag);
        for (int i = 0; i < 200 && m_state != 3; i++) step(0, 1, A_STAT, 0, tag);
        poll(2, tag);
    endtask

    task automatic dump(input string tag);
        for (int i = 0; i < DEPTH; i++) step(0, 1, {1'b1, AW'(i)}, 0, tag);
        poll(1, tag);
    endtask

    // hand-computed check of the reported trigger address and status bits
    task automatic hand_status(input int trig, input string tag);
        step(0, 1, A_STAT, 0, tag);
        @(posedge clk); #1;
        check(tag, 32'(cfg_rdata[AW+7:8]), 32'(trig));
        check(tag, 32'(cfg_rdata[1:0]), 32'd1);
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual still running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values of every register and read data
        @(negedge clk);
        check("R1", cfg_rdata, 32'd0);
        for (int r = 0; r <= 5; r++) step(0, 1, AW'(r), 0, "R1");
        poll(1, "R1");

        // R2: masked pattern, upper nibble only
        wr(A_MODE, 0, "R2"); wr(A_REFA, 32'hA5, "R2"); wr(A_REFB, 32'hF0, "R2");
        wr(A_PRE, 4, "R2");
        tp = 8'h15;
        wr(A_CTRL, 1, "R5");
        poll(6, "R8");
        tp = 8'hA3; poll(1, "R2");
        tp = 8'h15;
        run_to_done("R7");
        hand_status(6, "R2");
        dump("R4");

        // R3: range bounds, just outside then on the upper bound
        wr(A_MODE, 1, "R3"); wr(A_REFA, 32'h20, "R3"); wr(A_REFB, 32'h30, "R3");
        wr(A_PRE, 0, "R3");
        tp = 8'h00;
        wr(A_CTRL, 1, "R5");
        tp = 8'h1F; poll(1, "R3");
        tp = 8'h31; poll(1, "R3");
        tp = 8'h30; poll(1, "R3");
        tp = 8'h00;
        run_to_done("R3");
        hand_status(2, "R3");
        dump("R9");

        // R6: match held from arming, accepted with the PRE-th sample
        wr(A_MODE, 0, "R6"); wr(A_REFA, 32'h55, "R6"); wr(A_REFB, 32'hFF, "R6");
        wr(A_PRE, 8, "R6");
        tp = 8'h55;
        wr(A_CTRL, 1, "R6");
        run_to_done("R6");
        hand_status(8, "R6");
        dump("R4");

        // R10: re-arm during post-trigger while the probe matches
        wr(A_PRE, 2, "R10");
        wr(A_CTRL, 1, "R10");
        poll(5, "R10");
        wr(A_CTRL, 1, "R10");
        tp = 8'h00; poll(4, "R10");
        tp = 8'h55; poll(1, "R10");
        tp = 8'h00;
        run_to_done("R10");
        hand_status(4, "R10");

        // R11: reference write in the same cycle as the newly matching value
        wr(A_REFA, 32'h11, "R11"); wr(A_PRE, 0, "R11");
        tp = 8'h22;
        wr(A_CTRL, 1, "R11");
        tp = 8'h22; poll(3, "R11");
        wr(A_REFA, 32'h11, "R11");
        wr(A_REFA, 32'h22, "R11");
        run_to_done("R11");
        hand_status(5, "R11");

        // R7: maximum pre-trigger count stops on the trigger sample
        wr(A_REFA, 32'h55, "R7"); wr(A_PRE, DEPTH - 1, "R7");
        tp = 8'h55;
        wr(A_CTRL, 1, "R7");
        run_to_done("R7");
        hand_status(DEPTH - 1, "R7");
        dump("R7");

        @(negedge clk);
        check(exp_tag, cfg_rdata, exp_val);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule